// File: doc/BRIEF.md
# Pattern-Triggered Capture Buffer

This block watches a stream of 84-bit words that arrives one word per clock. A host arms it with a single command write. From then on it compares every incoming word against a programmable 84-bit pattern. A mask can exclude any of the ten low bytes and the top 4-bit nibble from that comparison. The first word that matches is stored as entry 0 of a 512-entry capture memory. The 511 words that follow are stored in order after it, and the block then stops and reports completion.

A host bus with a 12-bit word address and 32-bit data reaches the control registers and the capture memory. Host reads return one cycle after the request. Each memory entry is seen as four consecutive addresses, which lets software inspect or preload the captured data.

Top module: `ptc_capture_buf`

## Requirements
- R1: A host write of 1 in bit 0 of the command register (address 0x000) arms the block. The command register reads back as 0. State encoding, on `state_o` and in bits 1:0 of the status register (address 0x005): 0 idle, 1 armed, 2 capturing, 3 done. An arm from idle or done gives state 1 on the next cycle.
- R2: While armed, the first matching word is written to entry 0. The words that follow, one per clock, go to entries 1..511. After entry 511 the state becomes done and stays done until the next arm.
- R3: Mask register (address 0x001) bit k, for k = 0..9, excludes word bits 8k+7..8k from the compare. Bit 10 excludes bits 83..80. With a clear mask bit, a difference in that field prevents a match.
- R4: The pattern is held at 0x002 (bits 31:0), 0x003 (bits 63:32) and 0x004 (bits 83:64 in data bits 19:0). All three read back as written, with unused bits 0. Mask bits 31..11 read as 0.
- R5: Memory address 0x800 + 4*e + j reads entry e. Lane j=0 gives bits 31:0, j=1 gives bits 63:32, j=2 gives bits 83:64 zero-extended, and j=3 always reads 0.
- R6: Outside capture, a host write to lanes 0..2 of an entry replaces that slice of the entry. Lane 2 keeps only data bits 19:0. Writes to lane 3 have no effect.
- R7: In a cycle where the capture logic writes the memory, a host memory write is discarded. An arm request while capturing is ignored.
- R8: In the idle, armed and done states the memory keeps its contents. An arm from done restarts the sequence, and a new capture again fills from entry 0.
- R9: Read data for a request at clock edge t appears on `host_rdata` after edge t and is held until the next edge.
- R10: After reset the state is idle and the pattern and mask registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word and host clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 84 | Incoming stream word, one per cycle |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 12 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the read |
| state_o | output | 2 | Sequencer state (0 idle, 1 armed, 2 capturing, 3 done) |

## Verification
Two pairs of events can fall in the same cycle. A host memory write can coincide with a capture write, and an arm command can arrive during an active capture. The bench issues a host write to entry 5 and an arm write while the stream is being captured. It then checks two things: the full readback of entry 5 still equals the streamed word, and the state moves on to done without returning to armed.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    localparam int WORD_W   = 84;
    localparam int DEPTH    = 512;
    localparam int HOST_W   = 32;
    localparam int HADDR_W  = 12;
    localparam int PTR_W    = $clog2(DEPTH);
    localparam int N_BYTES  = 10;
    localparam int MASK_W   = N_BYTES + 1;
    localparam int N_LANES  = 3;
    localparam int TOP_W    = WORD_W - 2 * HOST_W;

    localparam logic [2:0] REG_CMD    = 3'd0;
    localparam logic [2:0] REG_MASK   = 3'd1;
    localparam logic [2:0] REG_PAT0   = 3'd2;
    localparam logic [2:0] REG_PAT1   = 3'd3;
    localparam logic [2:0] REG_PAT2   = 3'd4;
    localparam logic [2:0] REG_STATUS = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAP   = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic [HADDR_W-1:0] addr;
        logic [HOST_W-1:0]  wdata;
    } host_req_t;

    function automatic int lane_width(input int lane);
        return (lane == N_LANES - 1) ? TOP_W : HOST_W;
    endfunction

    function automatic int lane_low(input int lane);
        return lane * HOST_W;
    endfunction
endpackage

// File: rtl/ptc_match.sv
module ptc_match
    import ptc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] pattern,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    logic [MASK_W-1:0] field_ok;

    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        assign field_ok[k] = mask[k] || (word[8*k +: 8] == pattern[8*k +: 8]);
    end

    localparam int NIB_LO = 8 * N_BYTES;
    assign field_ok[N_BYTES] = mask[N_BYTES] ||
        (word[WORD_W-1:NIB_LO] == pattern[WORD_W-1:NIB_LO]);

    assign hit = &field_ok;
endmodule

// File: rtl/ptc_seq.sv
module ptc_seq
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             hit,
    output cap_state_e       state,
    output logic             cap_we,
    output logic [PTR_W-1:0] cap_addr
);
    cap_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;

    always_comb begin
        state_d  = state_q;
        ptr_d    = ptr_q;
        cap_we   = 1'b0;
        cap_addr = ptr_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (arm) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (hit) begin
                    cap_we   = 1'b1;
                    cap_addr = '0;
                    ptr_d    = PTR_W'(1);
                    state_d  = ST_CAP;
                end
            end
            ST_CAP: begin
                cap_we = 1'b1;
                ptr_d  = ptr_q + 1'b1;
                if (ptr_q == PTR_W'(DEPTH - 1)) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/ptc_store.sv
module ptc_store
    import ptc_pkg::*;
(
    input  logic              clk,
    input  logic              cap_we,
    input  logic [PTR_W-1:0]  cap_addr,
    input  logic [WORD_W-1:0] cap_data,
    input  logic              host_we,
    input  logic [1:0]        host_lane,
    input  logic [PTR_W-1:0]  host_idx,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [HOST_W-1:0] rd_lane [N_LANES]
);
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = lane_width(g);
        localparam int LO = lane_low(g);
        logic [LW-1:0] mem [DEPTH];
        logic [LW-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (cap_we)
                mem[cap_addr] <= cap_data[LO +: LW];
            else if (host_we && host_lane == 2'(g))
                mem[host_idx] <= host_wdata[LW-1:0];
            rd_q <= mem[rd_idx];
        end

        assign rd_lane[g] = HOST_W'(rd_q);
    end
endmodule

// File: rtl/ptc_capture_buf.sv
module ptc_capture_buf
    import ptc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ptc_pkg::WORD_W-1:0]  word_i,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [ptc_pkg::HADDR_W-1:0] host_addr,
    input  logic [ptc_pkg::HOST_W-1:0]  host_wdata,
    output logic [ptc_pkg::HOST_W-1:0]  host_rdata,
    output logic [1:0]               state_o
);
    host_req_t         req;
    logic [WORD_W-1:0] pattern_q;
    logic [MASK_W-1:0] mask_q;
    logic              hit, arm, cap_we, is_mem, host_mem_we;
    logic [PTR_W-1:0]  cap_addr;
    cap_state_e        state;
    logic [HOST_W-1:0] rd_lane [N_LANES];
    logic [HOST_W-1:0] reg_rd_q, reg_rd_d;
    logic              sel_mem_q;
    logic [1:0]        lane_sel_q;

    assign req    = '{wr: host_wr, rd: host_rd, addr: host_addr, wdata: host_wdata};
    assign is_mem = req.addr[HADDR_W-1];
    assign arm    = req.wr && !is_mem && req.addr[2:0] == REG_CMD && req.wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pattern_q <= '0;
            mask_q    <= '0;
        end else if (req.wr && !is_mem) begin
            unique case (req.addr[2:0])
                REG_MASK: mask_q <= req.wdata[MASK_W-1:0];
                REG_PAT0: pattern_q[HOST_W-1:0] <= req.wdata;
                REG_PAT1: pattern_q[2*HOST_W-1:HOST_W] <= req.wdata;
                REG_PAT2: pattern_q[WORD_W-1:2*HOST_W] <= req.wdata[TOP_W-1:0];
                default: ;
            endcase
        end
    end

    ptc_match u_match (
        .word    (word_i),
        .pattern (pattern_q),
        .mask    (mask_q),
        .hit     (hit)
    );

    ptc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .hit      (hit),
        .state    (state),
        .cap_we   (cap_we),
        .cap_addr (cap_addr)
    );

    assign host_mem_we = req.wr && is_mem && !cap_we && req.addr[1:0] != 2'd3;

    ptc_store u_store (
        .clk        (clk),
        .cap_we     (cap_we),
        .cap_addr   (cap_addr),
        .cap_data   (word_i),
        .host_we    (host_mem_we),
        .host_lane  (req.addr[1:0]),
        .host_idx   (req.addr[PTR_W+1:2]),
        .host_wdata (req.wdata),
        .rd_idx     (req.addr[PTR_W+1:2]),
        .rd_lane    (rd_lane)
    );

    always_comb begin
        reg_rd_d = '0;
        unique case (req.addr[2:0])
            REG_MASK:   reg_rd_d = HOST_W'(mask_q);
            REG_PAT0:   reg_rd_d = pattern_q[HOST_W-1:0];
            REG_PAT1:   reg_rd_d = pattern_q[2*HOST_W-1:HOST_W];
            REG_PAT2:   reg_rd_d = HOST_W'(pattern_q[WORD_W-1:2*HOST_W]);
            REG_STATUS: reg_rd_d = HOST_W'(state);
            default:    reg_rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rd_q   <= '0;
            sel_mem_q  <= 1'b0;
            lane_sel_q <= '0;
        end else if (req.rd) begin
            reg_rd_q   <= reg_rd_d;
            sel_mem_q  <= is_mem;
            lane_sel_q <= req.addr[1:0];
        end
    end

    always_comb begin
        if (!sel_mem_q)            host_rdata = reg_rd_q;
        else if (lane_sel_q == 2'd3) host_rdata = '0;
        else                       host_rdata = rd_lane[lane_sel_q];
    end

    assign state_o = state;
endmodule

// File: rtl/ptc_capture_buf_chk.sv
module ptc_capture_buf_chk
    import ptc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               arm,
    input logic               cap_we,
    input logic [1:0]         state,
    input logic               host_rd,
    input logic [HADDR_W-1:0] host_addr,
    input logic [HOST_W-1:0]  host_rdata
);
    logic [PTR_W:0] cap_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cap_cnt_q <= '0;
        else if (state == 2'(ST_CAP)) cap_cnt_q <= cap_cnt_q + 1'b1;
        else cap_cnt_q <= '0;
    end

    a_r1_arm_starts: assert property (@(posedge clk) disable iff (rst)
        (arm && (state == 2'(ST_IDLE) || state == 2'(ST_DONE))) |=> state == 2'(ST_ARMED));

    a_r2_full_length: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == 2'(ST_CAP) && state == 2'(ST_DONE)) |-> cap_cnt_q == (PTR_W+1)'(DEPTH - 1));

    a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
        state == 2'(ST_CAP) |-> cap_cnt_q < (PTR_W+1)'(DEPTH - 1));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
        (state == 2'(ST_DONE) && !arm) |=> state == 2'(ST_DONE));

    a_r8_quiet_memory: assert property (@(posedge clk) disable iff (rst)
        (state == 2'(ST_IDLE) || state == 2'(ST_DONE)) |-> !cap_we);

    a_r7_arm_ignored: assert property (@(posedge clk) disable iff (rst)
        state == 2'(ST_CAP) |=> (state == 2'(ST_CAP) || state == 2'(ST_DONE)));

    a_r4_mask_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == HADDR_W'(1)) |=> host_rdata[HOST_W-1:MASK_W] == '0);

    a_r9_status_latency: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == HADDR_W'(5)) |=> host_rdata == HOST_W'($past(state)));
endmodule

bind ptc_capture_buf ptc_capture_buf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .cap_we     (cap_we),
    .state      (state_o),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata)
);

// File: tb/ptc_capture_buf_bench.sv
module ptc_capture_buf_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [83:0] word_i = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  state_o;

    int n_tests = 0, n_fail = 0;
    int n = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        pend_q = 1'b0;

    always #5 clk = ~clk;

    ptc_capture_buf u_ptc_capture_buf (
        .clk(clk), .rst(rst), .word_i(word_i), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .state_o(state_o)
    );

    function automatic logic [83:0] mkword(input int k);
        logic [31:0] u;
        u = k;
        return {u[19:0], u * 32'h9E37_79B1, u ^ 32'hA5A5_0000};
    endfunction

    // stream: a fresh word at every falling edge
    always @(negedge clk) begin
        n <= n + 1;
        word_i <= mkword(n + 1);
    end

    // monitor: read data is due one edge after the request
    always @(posedge clk) pend_q <= host_rd;
    always @(negedge clk) begin
        if (pend_q) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (host_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", t, host_rdata, e);
            end
        end
    end

    task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", t, got, exp);
        end
    endtask

    task automatic idle_bus();
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b0; host_addr = a; host_wdata = d;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b1; host_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic set_pattern(input logic [83:0] p, input logic [10:0] m);
        wr(12'h002, p[31:0]);
        wr(12'h003, p[63:32]);
        wr(12'h004, {12'h0, p[83:64]});
        wr(12'h001, {21'h0, m});
    endtask

    task automatic rd_entry(input int e, input logic [83:0] w, input string t);
        logic [11:0] b;
        b = 12'h800 + 12'(4 * e);
        rd(b,     w[31:0], t);
        rd(b + 1, w[63:32], t);
        rd(b + 2, {12'h0, w[83:64]}, t);
        rd(b + 3, 32'h0, t);
    endtask

    task automatic wait_state(input logic [1:0] s, input int limit, input string t);
        int k;
        k = 0;
        idle_bus();
        while (state_o !== s && k < limit) begin
            @(negedge clk);
            k++;
        end
        check(t, 32'(state_o), 32'(s));
    endtask

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n0, n1, n2, n3;
        logic [83:0] p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 state after reset", 32'(state_o), 32'd0);
        rd(12'h001, 32'h0, "R10 mask reset");
        rd(12'h002, 32'h0, "R10 pattern reset");
        rd(12'h005, 32'h0, "R10 status idle");

        // R4 register readback
        wr(12'h001, 32'hFFFF_FFFF);
        rd(12'h001, 32'h0000_07FF, "R4 mask upper bits zero");
        n0 = n + 150;
        set_pattern(mkword(n0), 11'h0);
        rd(12'h002, mkword(n0)[31:0], "R4 pattern low");
        rd(12'h003, mkword(n0)[63:32], "R4 pattern mid");
        rd(12'h004, {12'h0, mkword(n0)[83:64]}, "R4 pattern top");

        // R1 arm, command self clears
        wr(12'h000, 32'h1);
        rd(12'h000, 32'h0, "R1 command reads zero");
        idle_bus();
        check("R1 armed", 32'(state_o), 32'd1);
        rd(12'h005, 32'h1, "R9 status read latency");

        // R7 collisions during capture
        wait_state(2'd2, 400, "R2 capture started");
        repeat (10) @(negedge clk);
        wr(12'h800 + 12'(4 * 5), 32'hDEAD_BEEF);
        wr(12'h000, 32'h1);
        idle_bus();
        check("R7 arm ignored while capturing", 32'(state_o), 32'd2);
        wait_state(2'd3, 700, "R2 done after 512 entries");
        for (int e = 0; e < 512; e++) rd_entry(e, mkword(n0 + e), "R2 R5 R7 captured entry");

        // R6 host writes outside capture
        wr(12'h800 + 12'(4 * 7 + 1), 32'h1122_3344);
        wr(12'h800 + 12'(4 * 7 + 2), 32'hFFFF_FFFF);
        wr(12'h800 + 12'(4 * 7 + 3), 32'h5555_5555);
        rd(12'h800 + 12'(4 * 7 + 0), mkword(n0 + 7)[31:0], "R6 untouched lane");
        rd(12'h800 + 12'(4 * 7 + 1), 32'h1122_3344, "R6 lane1 write");
        rd(12'h800 + 12'(4 * 7 + 2), 32'h000F_FFFF, "R6 lane2 20 bits");
        rd(12'h800 + 12'(4 * 7 + 3), 32'h0, "R6 lane3 ignored");

        // R8 memory holds while done
        idle_bus();
        repeat (60) @(negedge clk);
        check("R8 still done", 32'(state_o), 32'd3);
        rd_entry(0, mkword(n0), "R8 entry0 held");
        rd_entry(511, mkword(n0 + 511), "R8 entry511 held");

        // R3 byte mask: only byte 0 compared, others corrupted
        n1 = n + 120;
        p = mkword(n1) ^ {4'h0, {80{1'b1}}} ^ 84'hFF;
        set_pattern(p, 11'h7FE);
        wr(12'h000, 32'h1);
        idle_bus();
        check("R8 re-arm from done", 32'(state_o), 32'd1);
        wait_state(2'd3, 1000, "R3 masked capture done");
        rd_entry(0, mkword(n1), "R3 byte mask entry0");
        rd_entry(300, mkword(n1 + 300), "R8 restart fills in order");

        // R3 nibble mask
        n2 = n + 120;
        p = mkword(n2) ^ {4'hF, 80'h0};
        set_pattern(p, 11'h400);
        wr(12'h000, 32'h1);
        wait_state(2'd3, 1000, "R3 nibble capture done");
        rd_entry(0, mkword(n2), "R3 nibble mask entry0");

        // R3 unmasked mismatch never matches
        n3 = n + 60;
        p = mkword(n3) ^ (84'h1 << 32);
        set_pattern(p, 11'h0);
        wr(12'h000, 32'h1);
        idle_bus();
        repeat (200) @(negedge clk);
        check("R3 unmasked byte blocks match", 32'(state_o), 32'd1);
        rd_entry(0, mkword(n2), "R8 armed keeps memory");
        idle_bus();
        repeat (3) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule